// File: doc/BRIEF.md
# Wormhole Packet Switch with Per-Output Path Locking

This block is a four-in, four-out switching core for packets made of flits. Every input owns a small flit queue. A packet's opening flit names the output it wants. The first time that opening flit reaches the front of its queue while the output is unclaimed, it is sent on in the same cycle. From then on, the output serves that input alone.

Every later flit of the packet passes over the same connection, whatever its own destination bits say. The closing flit frees the connection as it leaves. When the path is held up, flits wait in the queues. Once a queue fills, the sender sees its ready signal drop. No flit is ever discarded.

When several opening flits compete for one free output, a per-output round-robin pointer chooses the winner. That pointer moves only when the winning packet's closing flit has been accepted. Input and output sides both use valid/ready handshakes. The destination arrives already computed inside the opening flit.

Top module: `wh_switch`

## Requirements
- R1: A flit is 70 bits wide. Bits [63:0] are payload, bits [65:64] are the kind (00 body, 01 head, 10 tail, 11 single-flit packet), bits [67:66] are the destination output, and bits [69:68] are spare. Every flit leaves bit-for-bit unchanged, and flits from one input leave in the order they were accepted.
- R2: A head or single flit that is at the front of its queue, while its destination output is unclaimed and chosen by arbitration, appears on that output in the same cycle. A flit accepted at a clock edge can therefore be on the output in the very next cycle.
- R3: Body and tail flits are routed only over the connection their head has claimed; their destination bits are ignored. Only head or single flits can start a packet on an unclaimed output.
- R4: A tail transfer releases its output. A single-flit packet claims and releases its output in the same cycle, so one output can carry single-flit packets from different inputs in consecutive cycles.
- R5: An output carries at most one input's flits at a time, and packets never interleave on an output.
- R6: Each output arbitrates round-robin, starting the search at the input just after the last winner whose tail (or single flit) was accepted. After reset the search starts at input 0.
- R7: While an output is claimed, head flits from other inputs that target it are held back, even when the owner has nothing to send.
- R8: Each input queue holds DEPTH flits (default 2). Its ready output is low while the queue is full, and no flit is lost.
- R9: An output whose valid is high while its ready is low keeps valid high and its flit unchanged in the next cycle.
- R10: Reset clears every claim and empties every queue, so all out_valid are low and all in_ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 4 | Per-input flit valid |
| in_ready | output | 4 | Per-input queue not full |
| in_flit | input | 4x70 | Per-input flit |
| out_valid | output | 4 | Per-output flit valid |
| out_ready | input | 4 | Per-output downstream ready |
| out_flit | output | 4x70 | Per-output flit |

## Verification
The queues are the only registered stage on the data path, so a flit accepted at one edge can appear at its output in the following cycle. A release takes effect for the very next arbitration. The bench drives inputs at the falling edge and samples one nanosecond later. Handshakes completed in that window are credited to the coming rising edge. A latency check therefore inspects the snapshot taken in the second cycle after the flit is queued; a ready-low hold check compares two consecutive snapshots; and the queue-full check looks at the snapshot after exactly DEPTH accepted pushes.

// File: rtl/wh_pkg.sv
package wh_pkg;
  typedef enum logic [1:0] {
    FK_BODY = 2'b00,
    FK_HEAD = 2'b01,
    FK_TAIL = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;

  // bit 0 of the kind marks a packet opener, bit 1 a packet closer
  function automatic logic kind_opens(input logic [1:0] k);
    return k[0];
  endfunction

  function automatic logic kind_closes(input logic [1:0] k);
    return k[1];
  endfunction
endpackage

// File: rtl/wh_flit_fifo.sv
module wh_flit_fifo #(
  parameter int W     = 70,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_pop,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign in_ready  = (cnt_q != CW'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rd_q];
  assign push      = in_valid && in_ready;

  always_comb begin
    wr_d  = push ? adv(wr_q) : wr_q;
    rd_d  = out_pop ? adv(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push && !out_pop)      cnt_d = cnt_q + CW'(1);
    else if (!push && out_pop) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= in_data;
  end

  // R8
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_pop |-> out_valid);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH)) && !out_pop |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/wh_rr_pick.sv
module wh_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          any,
  output logic [IW-1:0] win
);
  always_comb begin
    any = 1'b0;
    win = '0;
    for (int off = 0; off < N; off++) begin
      int cand;
      cand = (int'(ptr) + off) % N;
      if (!any && req[cand]) begin
        any = 1'b1;
        win = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/wh_out_alloc.sv
module wh_out_alloc #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          close_fire,
  output logic          sel_any,
  output logic [IW-1:0] sel_idx
);
  logic          locked_q, locked_d;
  logic [IW-1:0] owner_q, owner_d, ptr_q, ptr_d;
  logic          arb_any;
  logic [IW-1:0] arb_win;

  function automatic logic [IW-1:0] after(input logic [IW-1:0] p);
    return (p == IW'(N - 1)) ? '0 : p + IW'(1);
  endfunction

  wh_rr_pick #(.N(N), .IW(IW)) u_pick (
    .req (req),
    .ptr (ptr_q),
    .any (arb_any),
    .win (arb_win)
  );

  assign sel_any = locked_q || arb_any;
  assign sel_idx = locked_q ? owner_q : arb_win;

  always_comb begin
    locked_d = locked_q;
    owner_d  = owner_q;
    ptr_d    = ptr_q;
    if (locked_q) begin
      if (close_fire) begin
        locked_d = 1'b0;
        ptr_d    = after(owner_q);
      end
    end else if (arb_any) begin
      if (close_fire) begin
        ptr_d = after(arb_win);
      end else begin
        locked_d = 1'b1;
        owner_d  = arb_win;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
      ptr_q    <= '0;
    end else begin
      locked_q <= locked_d;
      owner_q  <= owner_d;
      ptr_q    <= ptr_d;
    end
  end

  // R7
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q && !close_fire |=> locked_q && $stable(owner_q));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !close_fire |=> $stable(ptr_q));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q && close_fire |=> !locked_q);
endmodule

// File: rtl/wh_switch.sv
module wh_switch #(
  parameter int NPORT  = 4,
  parameter int DEPTH  = 2,
  parameter int DATA_W = 64,
  parameter int CTRL_W = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NPORT-1:0]                      in_valid,
  output logic [NPORT-1:0]                      in_ready,
  input  logic [NPORT-1:0][DATA_W+CTRL_W-1:0]   in_flit,
  output logic [NPORT-1:0]                      out_valid,
  input  logic [NPORT-1:0]                      out_ready,
  output logic [NPORT-1:0][DATA_W+CTRL_W-1:0]   out_flit
);
  import wh_pkg::*;

  localparam int FW       = DATA_W + CTRL_W;
  localparam int IW       = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int KIND_LSB = DATA_W;
  localparam int DEST_LSB = DATA_W + 2;

  logic [NPORT-1:0][FW-1:0]    q_flit;
  logic [NPORT-1:0]            q_valid, q_pop;
  logic [NPORT-1:0][NPORT-1:0] reqm;
  logic [NPORT-1:0][NPORT-1:0] take;
  logic [NPORT-1:0]            sel_any, fire, close_fire;
  logic [NPORT-1:0][IW-1:0]    sel_idx;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    wh_flit_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid[i]),
      .in_ready  (in_ready[i]),
      .in_data   (in_flit[i]),
      .out_valid (q_valid[i]),
      .out_pop   (q_pop[i]),
      .out_data  (q_flit[i])
    );
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        reqm[o][i] = q_valid[i] && kind_opens(q_flit[i][KIND_LSB +: 2]) &&
                     (q_flit[i][DEST_LSB +: IW] == IW'(o));
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    wh_out_alloc #(.N(NPORT), .IW(IW)) u_alloc (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (reqm[o]),
      .close_fire (close_fire[o]),
      .sel_any    (sel_any[o]),
      .sel_idx    (sel_idx[o])
    );

    assign out_valid[o]  = sel_any[o] && q_valid[sel_idx[o]];
    assign out_flit[o]   = q_flit[sel_idx[o]];
    assign fire[o]       = out_valid[o] && out_ready[o];
    assign close_fire[o] = fire[o] && kind_closes(out_flit[o][KIND_LSB +: 2]);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_flit[o]));
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      for (int o = 0; o < NPORT; o++) begin
        take[i][o] = fire[o] && (sel_idx[o] == IW'(i));
      end
      q_pop[i] = |take[i];
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    // R5
    one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take[i]));
  end
endmodule

// File: tb/sim_wh_switch.sv
`timescale 1ns/1ps
module sim_wh_switch;
  localparam int NP    = 4;
  localparam int FW    = 70;
  localparam int DEPTH = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                  rst_n;
  logic [NP-1:0]         in_valid, in_ready, out_valid, out_ready;
  logic [NP-1:0][FW-1:0] in_flit, out_flit;

  wh_switch #(.NPORT(NP), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
  );

  int checks = 0;
  int fails  = 0;
  logic [FW-1:0] tx_q  [NP][$];
  logic [FW-1:0] exp_q [NP][$];
  int            log_q [NP][$];
  int            owner [NP];
  int            seq   [NP];
  int            acc_cnt [NP];
  logic [NP-1:0]         stall_prev;
  logic [NP-1:0][FW-1:0] flit_prev;
  logic [NP-1:0]         snap_ov, snap_ir;
  logic [NP-1:0][FW-1:0] snap_of;
  int rdy_mode;
  bit vld_rand;

  task automatic check(input bit ok, input string req,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic add_pkt(input int src, input int dst, input int len);
    for (int k = 0; k < len; k++) begin
      logic [1:0] kind, dbits, spare;
      if (len == 1)           kind = 2'b11;
      else if (k == 0)        kind = 2'b01;
      else if (k == len - 1)  kind = 2'b10;
      else                    kind = 2'b00;
      dbits = (k == 0) ? 2'(dst) : 2'($urandom % 4);
      spare = 2'($urandom % 4);
      tx_q[src].push_back({spare, dbits, kind, 4'(src), 60'(seq[src])});
      seq[src]++;
    end
  endtask

  task automatic monitor(input int o, input logic [FW-1:0] f);
    int src;
    logic [1:0] kind;
    src  = int'(f[63:60]);
    kind = f[65:64];
    if (src >= NP || exp_q[src].size() == 0) begin
      check(1'b0, "R1", f, '0);
      return;
    end
    check(f == exp_q[src][0], "R1", f, exp_q[src][0]);
    void'(exp_q[src].pop_front());
    if (owner[o] < 0) begin
      check(kind[0], "R3", FW'(kind), FW'(1));
      check(int'(f[67:66]) == o, "R2", FW'(f[67:66]), FW'(o));
      if (kind[0]) log_q[o].push_back(src);
      if (kind == 2'b01) owner[o] = src;
    end else begin
      check(src == owner[o], "R7", FW'(src), FW'(owner[o]));
      check(!kind[0], "R3", FW'(kind), FW'(2));
      if (kind[1]) owner[o] = -1;
    end
  endtask

  task automatic step();
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      in_valid[i] = (tx_q[i].size() > 0) && (!vld_rand || ($urandom % 4 != 0));
      in_flit[i]  = (tx_q[i].size() > 0) ? tx_q[i][0] : '0;
      out_ready[i] = (rdy_mode == 0) ? 1'b1 :
                     (rdy_mode == 1) ? 1'b0 : ($urandom % 10 < 7);
    end
    #1;
    snap_ov = out_valid;
    snap_ir = in_ready;
    snap_of = out_flit;
    for (int i = 0; i < NP; i++) begin
      if (in_valid[i] && in_ready[i]) begin
        exp_q[i].push_back(tx_q[i].pop_front());
        acc_cnt[i]++;
      end
    end
    for (int o = 0; o < NP; o++) begin
      if (stall_prev[o])
        check(out_valid[o] && out_flit[o] == flit_prev[o], "R9", out_flit[o], flit_prev[o]);
      if (out_valid[o] && out_ready[o]) monitor(o, out_flit[o]);
      stall_prev[o] = out_valid[o] && !out_ready[o];
      flit_prev[o]  = out_flit[o];
    end
    @(posedge clk);
  endtask

  function automatic bit busy();
    for (int i = 0; i < NP; i++)
      if (tx_q[i].size() > 0 || exp_q[i].size() > 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic drain();
    int n = 0;
    rdy_mode = 0;
    vld_rand = 0;
    while (busy() && n < 2000) begin
      step();
      n++;
    end
    check(!busy(), "R8", FW'(n), FW'(0));
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [FW-1:0] held;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    in_valid = '0; in_flit = '0; out_ready = '0;
    stall_prev = '0; flit_prev = '0;
    rdy_mode = 0; vld_rand = 0;
    for (int i = 0; i < NP; i++) begin
      owner[i] = -1; seq[i] = 0; acc_cnt[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    step();
    check(snap_ov == '0, "R10", FW'(snap_ov), '0);
    check(snap_ir == '1, "R10", FW'(snap_ir), FW'(4'hF));

    // R2 / R4: single-flit packets claim and release in one cycle
    add_pkt(0, 2, 1); add_pkt(0, 2, 1); add_pkt(1, 2, 1);
    step();
    step();
    check(snap_ov[2] && snap_of[2][63:60] == 4'd0, "R2", snap_of[2], '0);
    step();
    check(snap_ov[2] && snap_of[2][63:60] == 4'd1, "R4", FW'(snap_of[2][63:60]), FW'(1));
    step();
    check(snap_ov[2] && snap_of[2][63:60] == 4'd0, "R4", FW'(snap_of[2][63:60]), FW'(0));
    drain();

    // R5 / R6: contention on output 3
    add_pkt(0, 3, 2); add_pkt(1, 3, 2); add_pkt(2, 3, 2);
    step();
    step();
    check(snap_ov == 4'b1000 && snap_of[3][63:60] == 4'd0, "R5", FW'(snap_ov), FW'(4'b1000));
    drain();
    add_pkt(0, 3, 2); add_pkt(3, 3, 2);
    drain();
    check(log_q[3].size() == 5 && log_q[3][0] == 0 && log_q[3][1] == 1 &&
          log_q[3][2] == 2 && log_q[3][3] == 3 && log_q[3][4] == 0,
          "R6", FW'(log_q[3].size()), FW'(5));

    // R7: claimed output ignores another head while its owner is idle
    add_pkt(0, 1, 2);
    held = tx_q[0].pop_back();
    add_pkt(1, 1, 1);
    repeat (5) step();
    check(snap_ov == '0, "R7", FW'(snap_ov), '0);
    tx_q[0].push_back(held);
    drain();
    check(log_q[1].size() == 2 && log_q[1][0] == 0 && log_q[1][1] == 1,
          "R7", FW'(log_q[1].size()), FW'(2));

    // R8 / R9: full queue backpressure
    rdy_mode = 1;
    acc_cnt[0] = 0;
    add_pkt(0, 0, 5);
    repeat (4) step();
    check(acc_cnt[0] == DEPTH, "R8", FW'(acc_cnt[0]), FW'(DEPTH));
    check(snap_ir[0] == 1'b0, "R8", FW'(snap_ir[0]), '0);
    check(snap_ov[0] == 1'b1, "R9", FW'(snap_ov[0]), FW'(1));
    drain();

    // random traffic with random stalls on both sides
    rdy_mode = 2;
    vld_rand = 1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int i = 0; i < NP; i++)
        if (tx_q[i].size() < 4 && ($urandom % 3 == 0))
          add_pkt(i, int'($urandom % 4), 1 + int'($urandom % 4));
      step();
    end
    drain();

    summary();
    $finish;
  end
endmodule